// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block takes one interrupt request at a time and works out which processor slots it must reach. It reads a table of processor slots. For each slot the table gives a present flag, a physical ID, a logical ID mask and a current priority. From that table and the request's destination fields it forms a target set. It then issues one injection strobe per cycle to the selected targets. Each strobe carries the target slot index, the vector, the trigger mode and a kind flag that marks a normal or a non-maskable injection. When the sequence ends, a single-cycle completion pulse reports how many injections counted and whether the delivery mode was unsupported.

A request enters through a valid/ready handshake. The request port is ready only while the block is idle. The table is read on the accepting edge, and the target set is fixed from that moment. Each target answers its strobe in the same cycle on an accept input. That answer is used to count the delivered interrupts.

Top module: `irq_target_dispatch`

## Requirements
- R1: In physical mode (`req_logical`=0), a destination of all ones (0xFF at the default width) targets every slot whose present flag is set.
- R2: In physical mode with any other destination, only the lowest-indexed present slot whose physical ID equals the destination is targeted. Later slots with the same ID are not targeted.
- R3: In logical mode (`req_logical`=1), a zero destination targets nothing. Otherwise every present slot is targeted whose logical mask, ANDed bitwise with the destination, gives a non-zero result.
- R4: An empty target set completes with count 0 and error 0 one cycle after acceptance, and injects nothing. This holds whatever the delivery mode is, including unsupported modes.
- R5: Fixed mode (`req_dmode`=3'b000) injects to every target in ascending slot order, one per cycle, starting the cycle after acceptance. `inj_nmi` is 0, and the count equals the number of strobes answered with `inj_ok`=1.
- R6: Lowest-priority mode (`req_dmode`=3'b001) injects exactly once, to the target with the smallest priority value. A tie goes to the lowest slot index. The count is 1 if that strobe was accepted and 0 if it was not.
- R7: NMI mode (`req_dmode`=3'b100) sends a strobe with `inj_nmi`=1 to every target in ascending order. The count is 1 once any strobe has been sent, whatever `inj_ok` returns.
- R8: With `req_pin0`=1 and a non-empty target set, fixed and lowest-priority requests go only to slot 0, provided slot 0 is present. If slot 0 is absent, the request completes with count 0. NMI requests ignore `req_pin0`.
- R9: Any other delivery mode with a non-empty target set completes with error 1 and count 0 one cycle after acceptance, and injects nothing.
- R10: `req_ready` is high only when idle. `done_valid` pulses for exactly one cycle, in the cycle after the last injection, and the block is ready again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_present | input | NSLOT | Present flag for each slot |
| slot_phys_id | input | NSLOT*IDW | Physical ID of each slot, slot i at bits [i*IDW +: IDW] |
| slot_log_mask | input | NSLOT*IDW | Logical ID mask of each slot |
| slot_prio | input | NSLOT*PW | Current priority of each slot; a lower value wins |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken on valid and ready |
| req_vector | input | VW | Interrupt vector |
| req_trig | input | 1 | Trigger mode, carried to the injections |
| req_dmode | input | 3 | Delivery mode |
| req_dest | input | IDW | Destination ID or logical destination |
| req_logical | input | 1 | 1 selects logical destination mode |
| req_pin0 | input | 1 | Request comes from pin 0 |
| inj_valid | output | 1 | Injection strobe |
| inj_slot | output | SW | Target slot index |
| inj_nmi | output | 1 | 1 marks a non-maskable injection |
| inj_vector | output | VW | Vector of the injection |
| inj_trig | output | 1 | Trigger mode of the injection |
| inj_ok | input | 1 | Target accepted the strobe in this cycle |
| done_valid | output | 1 | Completion pulse |
| done_count | output | CW | Injection result count |
| done_err | output | 1 | Unsupported delivery mode |

## Verification
A corrupt pending-target register shows at the ports within one cycle. A slot is injected out of ascending order, or twice, or a wrong number of strobes comes before `done_valid`. A wrong mode or pin-0 latch shows in the first strobe as a wrong slot or a wrong `inj_nmi`. A faulty accumulator shows up in `done_count` on the completion pulse. Every scenario checks the full set of strobed slots, the cycle of the completion and the idle return directly after it. For this reason a state error is caught within the same request, no more than NSLOT+2 cycles after acceptance.

// File: rtl/irq_target_dispatch.sv
module irq_target_dispatch #(
  parameter int NSLOT = 8,
  parameter int IDW   = 8,
  parameter int PW    = 8,
  parameter int VW    = 8,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSLOT-1:0]     slot_present,
  input  logic [NSLOT*IDW-1:0] slot_phys_id,
  input  logic [NSLOT*IDW-1:0] slot_log_mask,
  input  logic [NSLOT*PW-1:0]  slot_prio,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VW-1:0]        req_vector,
  input  logic                 req_trig,
  input  logic [2:0]           req_dmode,
  input  logic [IDW-1:0]       req_dest,
  input  logic                 req_logical,
  input  logic                 req_pin0,
  output logic                 inj_valid,
  output logic [SW-1:0]        inj_slot,
  output logic                 inj_nmi,
  output logic [VW-1:0]        inj_vector,
  output logic                 inj_trig,
  input  logic                 inj_ok,
  output logic                 done_valid,
  output logic [CW-1:0]        done_count,
  output logic                 done_err
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;

  st_t              st;
  logic [NSLOT-1:0] pend;
  logic             nmi_q;
  logic             lp_q;
  logic [VW-1:0]    vec_q;
  logic             trig_q;
  logic [CW-1:0]    cnt_q;
  logic             err_q;

  logic [NSLOT-1:0] tset;
  logic [NSLOT-1:0] pick;
  logic [NSLOT-1:0] first_pend;
  logic [SW-1:0]    low_idx;
  logic [SW-1:0]    best_idx;
  logic             accept;

  wire is_fix = (req_dmode == 3'b000);
  wire is_lp  = (req_dmode == 3'b001);
  wire is_nmi = (req_dmode == 3'b100);
  wire bcast  = (req_dest == {IDW{1'b1}});

  assign accept = req_valid && req_ready;

  always_comb begin
    logic found;
    found = 1'b0;
    tset  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!req_logical) begin
        if (bcast)
          tset[i] = slot_present[i];
        else if (!found && slot_present[i] && slot_phys_id[i*IDW +: IDW] == req_dest) begin
          tset[i] = 1'b1;
          found   = 1'b1;
        end
      end else if (req_dest != '0 && slot_present[i] &&
                   (req_dest & slot_log_mask[i*IDW +: IDW]) != '0) begin
        tset[i] = 1'b1;
      end
    end
  end

  always_comb begin
    logic          have;
    logic [PW-1:0] best_p;
    have     = 1'b0;
    best_p   = '0;
    best_idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (tset[i] && (!have || slot_prio[i*PW +: PW] < best_p)) begin
        have     = 1'b1;
        best_p   = slot_prio[i*PW +: PW];
        best_idx = SW'(i);
      end
    end
  end

  always_comb begin
    pick = '0;
    if (tset != '0) begin
      if (is_nmi)
        pick = tset;
      else if ((is_fix || is_lp) && req_pin0)
        pick[0] = slot_present[0];
      else if (is_fix)
        pick = tset;
      else if (is_lp)
        pick[best_idx] = 1'b1;
    end
  end

  always_comb begin
    low_idx    = '0;
    first_pend = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = SW'(i);
    end
    first_pend[low_idx] = pend[low_idx];
  end

  wire last_one = ((pend & ~first_pend) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pend   <= '0;
      nmi_q  <= 1'b0;
      lp_q   <= 1'b0;
      vec_q  <= '0;
      trig_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          pend   <= pick;
          nmi_q  <= is_nmi;
          lp_q   <= is_lp;
          vec_q  <= req_vector;
          trig_q <= req_trig;
          cnt_q  <= '0;
          err_q  <= (tset != '0) && !(is_fix || is_lp || is_nmi);
          st     <= (pick == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          pend <= pend & ~first_pend;
          if (nmi_q)       cnt_q <= CW'(1);
          else if (inj_ok) cnt_q <= cnt_q + CW'(1);
          if (last_one) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign inj_valid  = (st == ST_RUN);
  assign inj_slot   = low_idx;
  assign inj_nmi    = nmi_q;
  assign inj_vector = vec_q;
  assign inj_trig   = trig_q;
  assign done_valid = (st == ST_DONE);
  assign done_count = cnt_q;
  assign done_err   = err_q;

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && $past(inj_valid) |-> inj_slot > $past(inj_slot));

  a_r6_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && lp_q |=> !inj_valid);

  a_r9_err_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> done_count == '0);

  a_r7_nmi_count: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && inj_nmi && !done_err |-> done_count <= CW'(1));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid || done_valid) |-> !req_ready);

  a_r4_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (pick == '0) |=> done_valid && done_count == '0);

endmodule

// File: tb/irq_target_dispatch_tb.sv
module irq_target_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSLOT-1:0] slot_present;
  logic [NSLOT*8-1:0] slot_phys_id, slot_log_mask, slot_prio;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_vector = '0;
  logic req_trig = 1'b0;
  logic [2:0] req_dmode = '0;
  logic [7:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic req_pin0 = 1'b0;
  logic inj_valid, inj_nmi, inj_trig, inj_ok;
  logic [2:0] inj_slot;
  logic [7:0] inj_vector;
  logic done_valid, done_err;
  logic [3:0] done_count;
  logic [NSLOT-1:0] rej_mask = '0;

  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign inj_ok = ~rej_mask[inj_slot];

  irq_target_dispatch dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input string req, input logic logical, input logic [7:0] dest,
                      input logic [2:0] mode, input logic pin0, input logic [7:0] exp_set,
                      input logic exp_nmi, input int exp_cnt, input logic exp_err);
    logic [7:0] got = '0;
    int last = -1;
    int cyc = 0;
    bit order_ok = 1'b1;
    bit kind_ok = 1'b1;
    bit seen_done = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_logical = logical; req_dest = dest; req_dmode = mode;
    req_pin0 = pin0; req_vector = 8'h40 + {5'd0, mode}; req_trig = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
    for (int c = 0; c < 20; c++) begin
      if (done_valid) begin seen_done = 1'b1; break; end
      if (inj_valid) begin
        if (int'(inj_slot) <= last || got[inj_slot]) order_ok = 1'b0;
        if (inj_nmi !== exp_nmi || inj_vector !== req_vector || inj_trig !== 1'b1) kind_ok = 1'b0;
        got[inj_slot] = 1'b1;
        last = int'(inj_slot);
      end
      cyc++;
      @(negedge clk);
    end
    chk(seen_done, req, "completion seen", seen_done, 1);
    chk(got == exp_set, req, "target set", got, exp_set);
    chk(order_ok, req, "ascending single strobes", order_ok, 1);
    chk(kind_ok, req, "strobe kind/vector", kind_ok, 1);
    chk(cyc == $countones(exp_set), "R10", "done cycle", cyc, $countones(exp_set));
    chk(int'(done_count) == exp_cnt, req, "count", done_count, exp_cnt);
    chk(done_err == exp_err, req, "error", done_err, exp_err);
    @(negedge clk);
    chk(!done_valid && req_ready, "R10", "idle after done", {done_valid, req_ready}, 1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(inj_valid == 1'b0, "R10", "reset inj", inj_valid, 0);
    chk(done_valid == 1'b0, "R10", "reset done", done_valid, 0);
  endtask

  task automatic t_physical;
    rej_mask = '0;
    send("R1", 0, 8'hFF, 3'b000, 0, 8'hBF, 0, 7, 0);
    rej_mask = 8'h04;
    send("R5", 0, 8'hFF, 3'b000, 0, 8'hBF, 0, 6, 0);
    rej_mask = '0;
    send("R2", 0, 8'h33, 3'b000, 0, 8'h08, 0, 1, 0);
    send("R2", 0, 8'h16, 3'b000, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic t_logical;
    send("R3", 1, 8'h00, 3'b000, 0, 8'h00, 0, 0, 0);
    send("R3", 1, 8'h81, 3'b000, 0, 8'h81, 0, 2, 0);
    send("R3", 1, 8'h40, 3'b000, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic t_lowest;
    send("R6", 1, 8'h7F, 3'b001, 0, 8'h08, 0, 1, 0);
    rej_mask = 8'h08;
    send("R6", 1, 8'h7F, 3'b001, 0, 8'h08, 0, 0, 0);
    rej_mask = '0;
    send("R6", 1, 8'h06, 3'b001, 0, 8'h02, 0, 1, 0);
  endtask

  task automatic t_nmi;
    rej_mask = 8'hFF;
    send("R7", 1, 8'h81, 3'b100, 0, 8'h81, 1, 1, 0);
    rej_mask = '0;
    send("R7", 0, 8'hFF, 3'b100, 1, 8'hBF, 1, 1, 0);
  endtask

  task automatic t_pin0;
    send("R8", 0, 8'hFF, 3'b000, 1, 8'h01, 0, 1, 0);
    send("R8", 1, 8'h28, 3'b001, 1, 8'h01, 0, 1, 0);
    send("R8", 1, 8'h00, 3'b001, 1, 8'h00, 0, 0, 0);
    slot_present[0] = 1'b0;
    send("R8", 1, 8'h28, 3'b000, 1, 8'h00, 0, 0, 0);
    slot_present[0] = 1'b1;
  endtask

  task automatic t_unsupported;
    send("R9", 0, 8'hFF, 3'b010, 0, 8'h00, 0, 0, 1);
    send("R4", 1, 8'h00, 3'b111, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    int pr[8] = '{30, 20, 50, 10, 40, 10, 5, 60};
    slot_present = 8'b1011_1111;
    for (int i = 0; i < NSLOT; i++) begin
      slot_phys_id[i*8 +: 8]  = 8'h10 + 8'(i);
      slot_log_mask[i*8 +: 8] = 8'h01 << i;
      slot_prio[i*8 +: 8]     = 8'(pr[i]);
    end
    slot_phys_id[3*8 +: 8]  = 8'h33;
    slot_phys_id[5*8 +: 8]  = 8'h33;
    slot_log_mask[7*8 +: 8] = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_logical();
    t_lowest();
    t_nmi();
    t_pin0();
    t_unsupported();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule